// File: doc/BRIEF.md
# Frame-Clock Loss-of-Sync Guard

This block sits in the system-clock domain of an audio DAC. It checks that the sample-rate frame clock keeps a fixed phase to the system clock. The frame clock is first passed through a two-flop synchronizer. Each rising edge of the synchronized signal is a frame marker. The block counts system clocks between consecutive markers and compares each count with the nominal frame length. The nominal length is 256 or 384 system clocks, chosen by a select input. The allowed deviation is six bit-clock periods, assuming 64 bit clocks per frame.

When a frame falls outside the window, or no marker arrives for twice the nominal length, the block does three things:
- It drops its lock flag.
- It emits a one-cycle halt strobe.
- It forces both output samples to midscale.

Lock is regained after two consecutive in-window frames. Both outputs then stay at midscale for 22 more good frames before the input samples are passed through again.

Top module: `lrck_sync_guard`

## Requirements
- R1: A frame marker is the rising edge of the frame clock after a two-flop synchronizer. A frame's length is the number of system clocks between two consecutive markers.
- R2: With `ratio_sel_i`=1 the nominal length is 384 clocks and the window is ±36 clocks. With `ratio_sel_i`=0 the nominal length is 256 clocks and the window is ±24 clocks.
- R3: A frame whose length differs from nominal by no more than the window is good. This includes both window limits. A frame that lies one clock beyond either limit is bad.
- R4: After reset the first marker only sets a reference. `locked_o` rises on the second of two consecutive good frames. After a loss, `locked_o` rises again on the second consecutive good frame.
- R5: A bad frame while `locked_o` is high clears `locked_o` and pulses `halt_o` high for exactly one cycle, in the same cycle.
- R6: If no marker arrives for twice the nominal length while a reference exists, that is a bad frame, and the reference is discarded. The next marker then only sets a new reference.
- R7: Whenever the block is not in pass-through, `left_o` and `right_o` equal midscale, 2^(SAMPLE_W-1) (0x800000 at 24 bits, offset binary). Midscale is present on the clock after `halt_o`.
- R8: After lock, the outputs stay at midscale until 22 further good frames have been seen. Pass-through starts after the 22nd. A bad frame in this interval returns the block to acquisition.
- R9: In pass-through, `left_o` and `right_o` follow `left_i` and `right_i` with one clock of latency.
- R10: During and right after reset, `locked_o` and `halt_o` are 0 and both outputs are midscale.
- R11: A bad frame while `locked_o` is low produces no `halt_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lrck_i | input | 1 | Frame clock, asynchronous to clk_i |
| ratio_sel_i | input | 1 | 1: 384 clocks per frame, 0: 256 clocks per frame |
| left_i | input | SAMPLE_W | Left input sample, offset binary |
| right_i | input | SAMPLE_W | Right input sample, offset binary |
| locked_o | output | 1 | Synchronization established |
| halt_o | output | 1 | One-cycle strobe on loss of synchronization |
| left_o | output | SAMPLE_W | Left output sample |
| right_o | output | SAMPLE_W | Right output sample |

## Verification
The bench builds the block with its default parameters: 24-bit samples, 256 and 384 clocks per frame, 64 bit clocks per frame, a six-bit-clock window and a 22-frame hold-off. It switches `ratio_sel_i` at run time, so both window sizes are checked: ±24 and ±36 clocks. At each ratio it places frames exactly on both window limits and one clock beyond them. The defaults keep the timeout near 512 or 768 clocks and the hold-off to 22 frames. This makes a full loss, relock and recovery sequence short enough to repeat for both ratios, for a loss during the hold-off and for a missing-edge timeout.

// File: rtl/lrck_guard_pkg.sv
package lrck_guard_pkg;
  typedef enum logic [1:0] {
    ST_ACQ     = 2'd0,
    ST_RECOVER = 2'd1,
    ST_RUN     = 2'd2
  } guard_state_e;
endpackage

// File: rtl/lrck_edge_sync.sv
module lrck_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_i,
  output logic mark_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], lrck_i};
  end

  // rising edge on the last synchronizer stage
  assign mark_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/lrck_frame_meter.sv
module lrck_frame_meter #(
  parameter int RATIO_LO       = 256,
  parameter int RATIO_HI       = 384,
  parameter int BCLK_PER_FRAME = 64,
  parameter int TOL_BCLK       = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mark_i,
  input  logic ratio_sel_i,
  output logic good_o,
  output logic bad_o
);
  localparam int CNT_W  = $clog2(2 * RATIO_HI + 1);
  localparam int TOL_LO = RATIO_LO * TOL_BCLK / BCLK_PER_FRAME;
  localparam int TOL_HI = RATIO_HI * TOL_BCLK / BCLK_PER_FRAME;
  localparam logic [CNT_W-1:0] MIN_LO = CNT_W'(RATIO_LO - TOL_LO);
  localparam logic [CNT_W-1:0] MAX_LO = CNT_W'(RATIO_LO + TOL_LO);
  localparam logic [CNT_W-1:0] MIN_HI = CNT_W'(RATIO_HI - TOL_HI);
  localparam logic [CNT_W-1:0] MAX_HI = CNT_W'(RATIO_HI + TOL_HI);
  localparam logic [CNT_W-1:0] TMO_LO = CNT_W'(2 * RATIO_LO);
  localparam logic [CNT_W-1:0] TMO_HI = CNT_W'(2 * RATIO_HI);

  logic [CNT_W-1:0] cnt_q, meas, win_min, win_max, tmo_lim;
  logic             have_ref_q, in_win, timeout;

  always_comb begin
    win_min = ratio_sel_i ? MIN_HI : MIN_LO;
    win_max = ratio_sel_i ? MAX_HI : MAX_LO;
    tmo_lim = ratio_sel_i ? TMO_HI : TMO_LO;
    meas    = cnt_q + CNT_W'(1);
    in_win  = (meas >= win_min) && (meas <= win_max);
    timeout = have_ref_q && !mark_i && (meas >= tmo_lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      have_ref_q <= 1'b0;
    end else if (mark_i) begin
      cnt_q      <= '0;
      have_ref_q <= 1'b1;
    end else if (timeout) begin
      cnt_q      <= '0;
      have_ref_q <= 1'b0;
    end else if (have_ref_q) begin
      cnt_q      <= meas;
    end
  end

  assign good_o = mark_i && have_ref_q && in_win;
  assign bad_o  = (mark_i && have_ref_q && !in_win) || timeout;
endmodule

// File: rtl/lrck_guard_fsm.sv
module lrck_guard_fsm
  import lrck_guard_pkg::*;
#(
  parameter int RECOVER_FRAMES = 22
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  input  logic bad_i,
  output logic locked_o,
  output logic mute_o,
  output logic halt_o
);
  localparam int REC_W = $clog2(RECOVER_FRAMES + 1);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(RECOVER_FRAMES - 1);

  guard_state_e     state_q, state_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic             prev_good_q, halt_q;

  always_comb begin
    state_d = state_q;
    rec_d   = rec_q;
    unique case (state_q)
      ST_ACQ: begin
        if (good_i && prev_good_q) begin
          state_d = ST_RECOVER;
          rec_d   = '0;
        end
      end
      ST_RECOVER: begin
        if (bad_i) state_d = ST_ACQ;
        else if (good_i) begin
          if (rec_q == REC_LAST) state_d = ST_RUN;
          else                   rec_d   = rec_q + REC_W'(1);
        end
      end
      ST_RUN: begin
        if (bad_i) state_d = ST_ACQ;
      end
      default: state_d = ST_ACQ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_ACQ;
      rec_q       <= '0;
      prev_good_q <= 1'b0;
      halt_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      rec_q   <= rec_d;
      if (bad_i)       prev_good_q <= 1'b0;
      else if (good_i) prev_good_q <= 1'b1;
      halt_q  <= bad_i && (state_q != ST_ACQ);
    end
  end

  assign locked_o = (state_q != ST_ACQ);
  assign mute_o   = (state_q != ST_RUN);
  assign halt_o   = halt_q;
endmodule

// File: rtl/lrck_sample_gate.sv
module lrck_sample_gate #(
  parameter int SAMPLE_W = 24,
  parameter int NUM_CH   = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             mute_i,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  smp_i,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0]  smp_o
);
  localparam logic [SAMPLE_W-1:0] MIDSCALE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [SAMPLE_W-1:0] out_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     out_q <= MIDSCALE;
      else if (mute_i) out_q <= MIDSCALE;
      else             out_q <= smp_i[ch];
    end
    assign smp_o[ch] = out_q;
  end
endmodule

// File: rtl/lrck_sync_guard.sv
module lrck_sync_guard #(
  parameter int SAMPLE_W       = 24,
  parameter int RATIO_LO       = 256,
  parameter int RATIO_HI       = 384,
  parameter int BCLK_PER_FRAME = 64,
  parameter int TOL_BCLK       = 6,
  parameter int RECOVER_FRAMES = 22,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lrck_i,
  input  logic                ratio_sel_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                locked_o,
  output logic                halt_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  localparam int NUM_CH = 2;

  logic mark, good, bad, mute;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_in, smp_out;

  lrck_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lrck_i(lrck_i),
    .mark_o(mark)
  );

  lrck_frame_meter #(
    .RATIO_LO      (RATIO_LO),
    .RATIO_HI      (RATIO_HI),
    .BCLK_PER_FRAME(BCLK_PER_FRAME),
    .TOL_BCLK      (TOL_BCLK)
  ) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mark_i     (mark),
    .ratio_sel_i(ratio_sel_i),
    .good_o     (good),
    .bad_o      (bad)
  );

  lrck_guard_fsm #(.RECOVER_FRAMES(RECOVER_FRAMES)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .good_i  (good),
    .bad_i   (bad),
    .locked_o(locked_o),
    .mute_o  (mute),
    .halt_o  (halt_o)
  );

  assign smp_in = {right_i, left_i};

  lrck_sample_gate #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mute_i(mute),
    .smp_i (smp_in),
    .smp_o (smp_out)
  );

  assign left_o  = smp_out[0];
  assign right_o = smp_out[1];
endmodule

// File: rtl/lrck_sync_guard_chk.sv
module lrck_sync_guard_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                locked_o,
  input logic                halt_o,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o
);
  localparam logic [SAMPLE_W-1:0] MID = {1'b1, {(SAMPLE_W-1){1'b0}}};

  AST_HALT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> !halt_o); // R5
  AST_HALT_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !locked_o); // R5
  AST_HALT_FROM_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> $past(locked_o)); // R11
  AST_MID_AFTER_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (left_o == MID && right_o == MID)); // R7
  AST_MID_WHILE_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(locked_o) |-> (left_o == MID && right_o == MID)); // R7
endmodule

bind lrck_sync_guard lrck_sync_guard_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .locked_o(locked_o),
  .halt_o  (halt_o),
  .left_o  (left_o),
  .right_o (right_o)
);

// File: tb/lrck_sync_guard_bench.sv
`timescale 1ns/1ps
module lrck_sync_guard_bench;
  localparam int W = 24;
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
  localparam int NV = 20;

  // {ratio[31], length[30:20], frames[19:12], 9'b0, lock[2], pass[1], halt[0]}
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 11'd384, 8'd2,  9'd0, 3'b000},  // R1 R4 first interval only reference+1
    {1'b1, 11'd384, 8'd1,  9'd0, 3'b100},  // R4 lock
    {1'b1, 11'd384, 8'd21, 9'd0, 3'b100},  // R8 still muted
    {1'b1, 11'd384, 8'd1,  9'd0, 3'b110},  // R8 22nd frame releases
    {1'b1, 11'd420, 8'd3,  9'd0, 3'b110},  // R3 upper limit
    {1'b1, 11'd348, 8'd3,  9'd0, 3'b110},  // R3 lower limit
    {1'b1, 11'd421, 8'd2,  9'd0, 3'b001},  // R3 R5 one beyond upper
    {1'b1, 11'd384, 8'd1,  9'd0, 3'b000},  // R4
    {1'b1, 11'd384, 8'd1,  9'd0, 3'b100},  // R4 relock
    {1'b1, 11'd384, 8'd22, 9'd0, 3'b110},  // R8
    {1'b1, 11'd347, 8'd2,  9'd0, 3'b001},  // R3 R5 one beyond lower
    {1'b0, 11'd256, 8'd3,  9'd0, 3'b100},  // R2 R11 bad while unlocked
    {1'b0, 11'd256, 8'd22, 9'd0, 3'b110},  // R2 R8
    {1'b0, 11'd280, 8'd3,  9'd0, 3'b110},  // R2 R3 upper limit
    {1'b0, 11'd232, 8'd2,  9'd0, 3'b110},  // R2 R3 lower limit
    {1'b0, 11'd231, 8'd2,  9'd0, 3'b001},  // R2 R3 beyond lower
    {1'b0, 11'd256, 8'd2,  9'd0, 3'b100},  // R4
    {1'b0, 11'd300, 8'd2,  9'd0, 3'b001},  // R8 loss during hold-off
    {1'b0, 11'd256, 8'd2,  9'd0, 3'b100},  // R4
    {1'b0, 11'd256, 8'd22, 9'd0, 3'b110}   // R8
  };

  logic clk = 1'b0, rst_n = 1'b0, lrck = 1'b0, ratio = 1'b1;
  logic [W-1:0] left_in = '0, right_in = '0;
  logic locked, halt;
  logic [W-1:0] left_out, right_out;
  int n_chk = 0, n_bad = 0, halt_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lrck_sync_guard u_lrck_sync_guard (
    .clk_i(clk), .rst_ni(rst_n), .lrck_i(lrck), .ratio_sel_i(ratio),
    .left_i(left_in), .right_i(right_in),
    .locked_o(locked), .halt_o(halt), .left_o(left_out), .right_o(right_out)
  );

  always @(negedge clk) if (rst_n && halt) halt_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input int len);
    lrck = 1'b0;
    repeat (len - len / 2) @(negedge clk);
    lrck = 1'b1;
    repeat (len / 2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    left_in = 24'h123456; right_in = 24'h654321;
    repeat (3) @(negedge clk);
    check("R10 locked in reset", 32'(locked), 32'd0);
    check("R10 halt in reset", 32'(halt), 32'd0);
    check("R10 left in reset", 32'(left_out), 32'(MID));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 right after reset", 32'(right_out), 32'(MID));
    check("R10 locked after reset", 32'(locked), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      int h0;
      v = VEC[i];
      ratio    = v[31];
      left_in  = 24'h0A0000 + W'(i);
      right_in = 24'hF00000 - W'(i);
      h0 = halt_cnt;
      for (int k = 0; k < int'(v[19:12]); k++) frame(int'(v[30:20]));
      check($sformatf("R4 R5 locked vec %0d", i), 32'(locked), 32'(v[2]));
      check($sformatf("R7 R9 left vec %0d", i), 32'(left_out),
            v[1] ? 32'(left_in) : 32'(MID));
      check($sformatf("R7 R9 right vec %0d", i), 32'(right_out),
            v[1] ? 32'(right_in) : 32'(MID));
      check($sformatf("R5 R11 halt pulses vec %0d", i), 32'(halt_cnt - h0), 32'(v[0]));
    end

    // R9: one-clock latency in pass-through
    left_in = 24'h00ABCD; right_in = 24'hFEDCBA;
    check("R9 left before edge", 32'(left_out), 32'(24'h0A0013));
    @(negedge clk);
    check("R9 left one clock", 32'(left_out), 32'(24'h00ABCD));
    check("R9 right one clock", 32'(right_out), 32'(24'hFEDCBA));

    // R6: missing edge timeout at 2x256
    begin
      int h0;
      h0 = halt_cnt;
      lrck = 1'b0;
      repeat (300) @(negedge clk);
      check("R6 still locked before timeout", 32'(locked), 32'd1);
      repeat (120) @(negedge clk);
      check("R6 unlocked after timeout", 32'(locked), 32'd0);
      check("R6 R5 halt on timeout", 32'(halt_cnt - h0), 32'd1);
      check("R6 R7 midscale after timeout", 32'(left_out), 32'(MID));
      frame(256); frame(256);
      check("R6 reference discarded", 32'(locked), 32'd0);
      frame(256);
      check("R6 R4 relock after timeout", 32'(locked), 32'd1);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule